// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes in characters from the single bidirectional data line of a smart card, which is shared with the card. In the idle state it watches for the line to fall. That falling edge marks the start bit. The block then samples the start bit, eight data bits and one parity bit, each at the centre of its elementary time unit (etu). A character whose parity is good is presented on `rx_data` with a one-cycle `rx_valid` strobe. A character whose parity is bad is dropped. It is reported with a one-cycle `parity_err` pulse, and the block pulls the shared line low for exactly one etu so that the card sends the character again.

Two inputs set the coding. `conv_inverse` selects the bit order and the level sense. `parity_odd` selects the parity sense. Both inputs must be held stable while a character is being received. `io_line` is the resolved level of the open-drain line and is assumed to be synchronous to `clk`. `io_drive_low` enables the pull-down on the pad. One etu is `ETU_CYCLES` clock cycles.

In the timing below, "edge cycle" means the rising clock edge at which `io_line` is first sampled low after being sampled high while the receiver is idle. H is `ETU_CYCLES/2` and E is `ETU_CYCLES`.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_valid`, `parity_err` and `io_drive_low` are 0.
- R2: In direct convention (`conv_inverse`=0), a high line is 1, a low line is 0, and the first data bit received is bit 0 of `rx_data`. A good character raises `rx_valid` for exactly one cycle, in the cycle after the clock edge H+9E cycles after the edge cycle. `rx_data` holds the byte while `rx_valid` is high.
- R3: In inverse convention (`conv_inverse`=1), a low line is 1, a high line is 0, and the first data bit received is bit 7 of `rx_data`.
- R4: With `parity_odd`=0, the eight data bits plus the parity bit, taken as logical values, must contain an even number of ones. With `parity_odd`=1, they must contain an odd number of ones.
- R5: A character that fails the parity check produces no `rx_valid`. Instead, `parity_err` is high for one cycle, at the cycle where `rx_valid` would have been high.
- R6: After a parity failure, `io_drive_low` rises in the cycle after the clock edge H+10E cycles after the edge cycle, which is 10.5 etu after the start edge. It stays high for exactly E cycles.
- R7: If the start bit is high again at its midpoint, it is treated as a glitch. The receiver returns to idle with no output, and it then receives the next character correctly.
- R8: The receiver does not take the low level of its own error pulse as a start bit. It looks for a new start edge only after the pulse has ended and the line has returned high.
- R9: Two characters separated by a 2 etu guard time are both received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_inverse | input | 1 | 0: direct convention, 1: inverse convention |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| io_line | input | 1 | Resolved level of the shared card data line |
| io_drive_low | output | 1 | Enables the pull-down on the line during the error pulse |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a good character |
| parity_err | output | 1 | One-cycle pulse for a rejected character |

## Verification
The bench builds the block with `ETU_CYCLES` = 16 instead of the default 372. This gives a half-etu offset of 8 cycles, so a whole character and its error pulse fit in about 200 cycles. At that length the exact cycle of the strobe and of the error pulse can be checked against the H+9E and H+10E formulas in every scenario. The short etu also makes the bench affordable for glitch starts, back-to-back characters with the minimum guard time, and recovery after an error pulse.

// File: rtl/sc_rx_pkg.sv
// Shared types for the smart card character receiver.
package sc_rx_pkg;

    // Receiver control states
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a falling start edge
        ST_START,   // timing to the start bit midpoint
        ST_BITS,    // sampling data bits and the parity bit
        ST_GAP,     // waiting from the parity midpoint to the error slot
        ST_ERRDRV,  // driving the line low for one etu
        ST_RELEASE  // waiting for the line to return high
    } rx_state_t;

endpackage

// File: rtl/sc_etu_timer.sv
// Elementary time unit timer.
// Counts clock cycles and ticks either after half an etu (in the start
// phase) or after a whole etu. The count restarts on clear and on every tick.
// Assumes ETU_CYCLES >= 4.
module sc_etu_timer #(
    parameter int ETU_CYCLES = 372
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic use_half,
    output logic tick
);
    localparam int CNT_W = $clog2(ETU_CYCLES);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(ETU_CYCLES / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(ETU_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Tick when the count reaches the selected interval end
    always_comb begin
        tick = (cnt == (use_half ? HALF_LAST : FULL_LAST));
    end

    // Cycle counter, restarted by clear or by a tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sc_rx_shift.sv
// Data assembly for received bits.
// Shifts logical bit values into a byte in either order and keeps a running
// parity over everything shifted in since the last clear.
// Assumes msb_first is stable for the whole character.
module sc_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_logical,
    input  logic              msb_first,
    output logic [DATA_W-1:0] data,
    output logic              par_acc
);
    // Shift register: LSB-first fills from the top, MSB-first from the bottom
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (shift_en) begin
            if (msb_first) begin
                data <= {data[DATA_W-2:0], bit_logical};
            end else begin
                data <= {bit_logical, data[DATA_W-1:1]};
            end
        end
    end

    // Running parity of the bits shifted in
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            par_acc <= 1'b0;
        end else if (shift_en) begin
            par_acc <= par_acc ^ bit_logical;
        end
    end
endmodule

// File: rtl/sc_rx_ctrl.sv
// Control for the character receiver.
// Detects the start edge, confirms the start bit at its midpoint, counts
// the data and parity bits, judges parity, and times the one-etu error pulse.
// Assumes io_line is synchronous to clk.
module sc_rx_ctrl
    import sc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_line,
    input  logic bit_logical,
    input  logic parity_odd,
    input  logic par_acc,
    input  logic tick,
    output logic timer_clear,
    output logic timer_half,
    output logic shift_clear,
    output logic shift_en,
    output logic rx_valid,
    output logic parity_err,
    output logic io_drive_low
);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(DATA_W);

    rx_state_t        state;
    logic [IDX_W-1:0] bit_idx;
    logic             line_prev;
    logic             start_edge;
    logic             par_bad;

    // Falling edge of the line and the parity verdict
    always_comb begin
        start_edge = line_prev && !io_line;
        par_bad    = par_acc ^ bit_logical ^ parity_odd;
    end

    // Strobes for the timer and the shifter
    always_comb begin
        timer_clear = (state == ST_IDLE);
        timer_half  = (state == ST_START);
        shift_clear = (state == ST_IDLE);
        shift_en    = (state == ST_BITS) && tick && (bit_idx != PAR_IDX);
    end

    // Previous line level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
        end else begin
            line_prev <= io_line;
        end
    end

    // Receive sequence and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bit_idx      <= '0;
            rx_valid     <= 1'b0;
            parity_err   <= 1'b0;
            io_drive_low <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_edge) begin
                        state <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        bit_idx <= '0;
                        state   <= io_line ? ST_IDLE : ST_BITS;
                    end
                end
                ST_BITS: begin
                    if (tick) begin
                        if (bit_idx == PAR_IDX) begin
                            if (par_bad) begin
                                parity_err <= 1'b1;
                                state      <= ST_GAP;
                            end else begin
                                rx_valid <= 1'b1;
                                state    <= ST_RELEASE;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        io_drive_low <= 1'b1;
                        state        <= ST_ERRDRV;
                    end
                end
                ST_ERRDRV: begin
                    if (tick) begin
                        io_drive_low <= 1'b0;
                        state        <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (io_line) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
// Smart card character receiver, top level.
// Joins the etu timer, the bit assembler and the control. ETU_CYCLES is the
// number of clock cycles in one elementary time unit. Assumes conv_inverse
// and parity_odd are stable during a character.
module sc_char_rx #(
    parameter int ETU_CYCLES = 372,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_inverse,
    input  logic              parity_odd,
    input  logic              io_line,
    output logic              io_drive_low,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err
);
    logic bit_logical;
    logic tick;
    logic timer_clear;
    logic timer_half;
    logic shift_clear;
    logic shift_en;
    logic par_acc;

    // Line level to logical value under the selected convention
    always_comb begin
        bit_logical = io_line ^ conv_inverse;
    end

    sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .use_half (timer_half),
        .tick     (tick)
    );

    sc_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (shift_clear),
        .shift_en    (shift_en),
        .bit_logical (bit_logical),
        .msb_first   (conv_inverse),
        .data        (rx_data),
        .par_acc     (par_acc)
    );

    sc_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_line      (io_line),
        .bit_logical  (bit_logical),
        .parity_odd   (parity_odd),
        .par_acc      (par_acc),
        .tick         (tick),
        .timer_clear  (timer_clear),
        .timer_half   (timer_half),
        .shift_clear  (shift_clear),
        .shift_en     (shift_en),
        .rx_valid     (rx_valid),
        .parity_err   (parity_err),
        .io_drive_low (io_drive_low)
    );
endmodule

// File: rtl/sc_char_rx_chk.sv
// Assertion checker for sc_char_rx, attached with bind.
// Measures the error pulse width and its distance from the parity failure
// with counters, so no window depends on a large $past depth.
module sc_char_rx_chk #(
    parameter int ETU_CYCLES = 372
) (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic parity_err,
    input logic io_drive_low
);
    localparam int W = $clog2(2 * ETU_CYCLES + 2) + 1;
    localparam logic [W-1:0] ETU_V = W'(ETU_CYCLES);
    localparam logic [W-1:0] SAT_V = W'(2 * ETU_CYCLES);

    logic [W-1:0] drv_len;
    logic [W-1:0] since_err;

    // Length of the current error pulse, in cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !io_drive_low) begin
            drv_len <= '0;
        end else begin
            drv_len <= drv_len + 1'b1;
        end
    end

    // Cycles since the last parity failure, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_err <= SAT_V;
        end else if (parity_err) begin
            since_err <= W'(1);
        end else if (since_err != SAT_V) begin
            since_err <= since_err + 1'b1;
        end
    end

    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |=> !parity_err);
    a_r5_valid_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && parity_err));
    a_r6_pulse_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive_low |-> (drv_len < ETU_V));
    a_r6_pulse_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_drive_low) |-> (drv_len == ETU_V));
    a_r6_pulse_one_etu_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_drive_low) |-> (since_err == ETU_V));
    a_r8_no_valid_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive_low |-> !rx_valid);
endmodule

bind sc_char_rx sc_char_rx_chk #(.ETU_CYCLES(ETU_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .parity_err   (parity_err),
    .io_drive_low (io_drive_low)
);

// File: tb/sc_char_rx_tb.sv
`timescale 1ns/1ps
// Directed bench for sc_char_rx. Each scenario task drives the line and
// checks its own results through counters kept by the negedge monitor.
module sc_char_rx_tb;
    localparam int ETU  = 16;
    localparam int HALF = ETU / 2;
    localparam int VALID_OFS = 1 + HALF + 9 * ETU;
    localparam int DRV_OFS   = 1 + HALF + 10 * ETU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_inverse = 1'b0;
    logic       parity_odd = 1'b0;
    logic       bench_line = 1'b1;
    logic       io_line;
    logic       io_drive_low;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       parity_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_valid = 0;
    int n_err = 0;
    int n_drv = 0;
    int drv_width = 0;
    int first_drv_cyc = -1;
    int last_valid_cyc = -1;
    int last_err_cyc = -1;
    logic [7:0] last_data = 8'h00;
    logic drv_prev = 1'b0;
    logic [7:0] data_hist [0:1];

    assign io_line = bench_line & ~io_drive_low;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid) begin
            data_hist[n_valid % 2] = rx_data;
            n_valid = n_valid + 1;
            last_data = rx_data;
            last_valid_cyc = cyc;
        end
        if (parity_err) begin
            n_err = n_err + 1;
            last_err_cyc = cyc;
        end
        if (io_drive_low) begin
            if (!drv_prev) begin
                n_drv = n_drv + 1;
                first_drv_cyc = cyc;
                drv_width = 0;
            end
            drv_width = drv_width + 1;
        end
        drv_prev = io_drive_low;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive one character; returns the cycle count at the start negedge
    task automatic send_char(input logic [7:0] data, input logic bad_parity, output int c0);
        logic par;
        logic lv [0:9];
        par = (^data) ^ parity_odd ^ bad_parity;
        lv[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            lv[i + 1] = conv_inverse ? ~data[7 - i] : data[i];
        end
        lv[9] = conv_inverse ? ~par : par;
        @(negedge clk);
        c0 = cyc;
        for (int b = 0; b < 10; b++) begin
            bench_line = lv[b];
            repeat (ETU) @(negedge clk);
        end
        bench_line = 1'b1;
    endtask

    task automatic idle_etu(input int n);
        repeat (n * ETU) @(negedge clk);
    endtask

    task automatic good_char(input string req, input logic [7:0] data);
        int c0;
        int nv0;
        nv0 = n_valid;
        send_char(data, 1'b0, c0);
        idle_etu(3);
        check({req, " valid count"}, n_valid - nv0, 1);
        check({req, " data"}, int'(last_data), int'(data));
        check({req, " valid timing"}, last_valid_cyc - c0, VALID_OFS);
    endtask

    task automatic test_reset();
        check("R1 rx_valid", int'(rx_valid), 0);
        check("R1 parity_err", int'(parity_err), 0);
        check("R1 io_drive_low", int'(io_drive_low), 0);
    endtask

    task automatic test_direct();
        conv_inverse = 1'b0;
        parity_odd = 1'b0;
        good_char("R2 direct 0xA5", 8'hA5);
        good_char("R2 direct 0x01", 8'h01);
    endtask

    task automatic test_inverse();
        conv_inverse = 1'b1;
        parity_odd = 1'b0;
        good_char("R3 inverse 0x3F", 8'h3F);
        good_char("R3 inverse 0x80", 8'h80);
        conv_inverse = 1'b0;
    endtask

    task automatic test_odd();
        parity_odd = 1'b1;
        good_char("R4 odd 0x5A", 8'h5A);
        good_char("R4 odd 0x07", 8'h07);
        parity_odd = 1'b0;
    endtask

    task automatic test_parity_error();
        int c0;
        int nv0;
        int ne0;
        int nd0;
        nv0 = n_valid;
        ne0 = n_err;
        nd0 = n_drv;
        send_char(8'hC3, 1'b1, c0);
        idle_etu(4);
        check("R5 no valid on bad parity", n_valid - nv0, 0);
        check("R5 one error pulse", n_err - ne0, 1);
        check("R5 error timing", last_err_cyc - c0, VALID_OFS);
        check("R6 drive count", n_drv - nd0, 1);
        check("R6 drive start", first_drv_cyc - c0, DRV_OFS);
        check("R6 drive width", drv_width, ETU);
        idle_etu(4);
        check("R8 no frame from own pulse", n_valid - nv0, 0);
        check("R8 no second error", n_err - ne0, 1);
        good_char("R8 recovery", 8'h69);
        conv_inverse = 1'b1;
        parity_odd = 1'b1;
        nv0 = n_valid;
        ne0 = n_err;
        send_char(8'h12, 1'b1, c0);
        idle_etu(6);
        check("R5 inverse odd rejected", n_valid - nv0, 0);
        check("R4 inverse odd error", n_err - ne0, 1);
        conv_inverse = 1'b0;
        parity_odd = 1'b0;
    endtask

    task automatic test_glitch();
        int nv0;
        int ne0;
        nv0 = n_valid;
        ne0 = n_err;
        @(negedge clk);
        bench_line = 1'b0;
        repeat (3) @(negedge clk);
        bench_line = 1'b1;
        idle_etu(14);
        check("R7 glitch no valid", n_valid - nv0, 0);
        check("R7 glitch no error", n_err - ne0, 0);
        good_char("R7 after glitch", 8'hE4);
    endtask

    task automatic test_back_to_back();
        int c0;
        int c1;
        int nv0;
        nv0 = n_valid;
        send_char(8'h96, 1'b0, c0);
        idle_etu(2);
        send_char(8'h3C, 1'b0, c1);
        idle_etu(3);
        check("R9 two characters", n_valid - nv0, 2);
        check("R9 first byte", int'(data_hist[nv0 % 2]), 8'h96);
        check("R9 second byte", int'(data_hist[(nv0 + 1) % 2]), 8'h3C);
        check("R9 second timing", last_valid_cyc - c1, VALID_OFS);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        idle_etu(1);
        test_direct();
        test_inverse();
        test_odd();
        test_parity_error();
        test_glitch();
        test_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(150000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    sc_char_rx #(.ETU_CYCLES(ETU)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_inverse (conv_inverse),
        .parity_odd   (parity_odd),
        .io_line      (io_line),
        .io_drive_low (io_drive_low),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .parity_err   (parity_err)
    );
endmodule